// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

This block watches a bank of asynchronous input lines and turns qualified transitions on them into interrupt requests and hardware event pulses. Every line is first brought into the clock domain through a short synchronizer chain. Its synchronized level is then compared with the value from the previous cycle, and the result is checked against the line's own rising and falling trigger selections. A qualified edge, or a software trigger request for the same line, sets a sticky pending bit. That bit stays set until software writes a 1 to clear it.

Each line has two separate output paths. The interrupt path gives a level request, which is the pending bit gated by the line's interrupt mask. It stays asserted until the handler clears the pending bit. The event path gives a single-cycle pulse in the cycle that follows a qualified edge. It is gated only by the line's event mask, so other hardware can react without any software involvement. Priority arbitration and vectoring are handled by the interrupt controller downstream.

Software reaches the configuration through a small register port. It writes in one cycle, and read data comes back registered one cycle later.

Top module: `eil_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following are zero: trigger selections, interrupt mask, event mask, software trigger, pending bits, `irq_o`, `evt_o` and `reg_rdata`.
- R2: A level on `line_in` that is present at clock edge k is synchronized and compared as follows: if it qualifies as an edge, the pending bit and `evt_o` are set after edge k+2, and `irq_o` is set after edge k+3.
- R3: When a line's rising-select bit is 1, a 0-to-1 transition of its synchronized level is a qualified edge.
- R4: When a line's falling-select bit is 1, a 1-to-0 transition is a qualified edge. With both bits set, either direction qualifies. With neither set, the line never sets pending and never pulses `evt_o`.
- R5: A pending bit stays set until a write to address 5 carries a 1 in that bit position. Bits written as 0 leave their pending bits unchanged.
- R6: If a qualified edge or a software trigger sets a pending bit in the same cycle that a write-1 clears it, the bit ends up set.
- R7: `irq_o[i]` equals pending[i] AND interrupt-mask[i], registered one cycle. A masked line keeps its pending bit, and the request appears as soon as the mask is set.
- R8: `evt_o[i]` is a one-cycle pulse for each qualified edge. It is gated only by event-mask[i] and does not depend on the interrupt mask. A software trigger produces no event pulse.
- R9: A write to address 5's neighbour, address 4 (software trigger), sets the pending bits for every 1 written, one cycle after the write. The trigger register clears itself after that one cycle and always reads back as 0.
- R10: The register map is: 0 rising select, 1 falling select, 2 interrupt mask, 3 event mask, 4 software trigger, 5 pending (write 1 to clear). Addresses 6 and 7 read as 0 and ignore writes. `reg_rdata` presents the contents of `reg_addr` as they stood before the sampling edge, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 16 | Asynchronous external lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 16 | Register write data, one bit per line |
| reg_rdata | output | 16 | Registered read data |
| irq_o | output | 16 | Level interrupt request per line |
| evt_o | output | 16 | Single-cycle event pulse per line |

## Verification
Three things can collide in one cycle on the pending register: a qualified edge arriving from the synchronizer, a software trigger maturing, and a write-1 clear. The bench provokes these collisions by timing the clear write to land on the cycle two edges after a pin change, or on the cycle right after a trigger write. It then checks that the bit stays set, and that `irq_o` stays asserted one cycle later. A behavioural per-cycle model predicts all three outputs, and a long pseudo-random phase exercises further coincidences between edges, clears, trigger writes and mask changes.

// File: rtl/eil_pkg.sv
package eil_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_RISE   = 3'd0,
    REG_FALL   = 3'd1,
    REG_IMASK  = 3'd2,
    REG_EMASK  = 3'd3,
    REG_SWTRIG = 3'd4,
    REG_PEND   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/eil_edge_detect.sv
module eil_edge_detect #(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] rise_sel,
  input  logic [NUM_LINES-1:0] fall_sel,
  output logic [NUM_LINES-1:0] hit
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   cur;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], line_in[g]};
        prev  <= chain[TOP];
      end
    end

    assign cur = chain[TOP];
    assign hit[g] = (rise_sel[g] & cur & ~prev) | (fall_sel[g] & ~cur & prev);

    // A hit requires the synchronized level to have changed (R3, R4)
    p_hit_on_change_r4: assert property (@(posedge clk) disable iff (rst)
      hit[g] |-> (cur != prev));
  end
endmodule

// File: rtl/eil_regs.sv
module eil_regs
  import eil_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NUM_LINES-1:0]  wdata,
  input  logic [NUM_LINES-1:0]  pend_q,
  output logic [NUM_LINES-1:0]  rise_sel,
  output logic [NUM_LINES-1:0]  fall_sel,
  output logic [NUM_LINES-1:0]  imask,
  output logic [NUM_LINES-1:0]  emask,
  output logic [NUM_LINES-1:0]  swtrig,
  output logic [NUM_LINES-1:0]  clr,
  output logic [NUM_LINES-1:0]  rdata
);
  reg_sel_e            sel;
  logic [NUM_LINES-1:0] rd_mux;
  logic                 hit_sw;

  assign sel    = reg_sel_e'(addr);
  assign hit_sw = we && (sel == REG_SWTRIG);
  assign clr    = (we && (sel == REG_PEND)) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_sel <= '0;
      fall_sel <= '0;
      imask    <= '0;
      emask    <= '0;
      swtrig   <= '0;
    end else begin
      swtrig <= hit_sw ? wdata : '0;
      if (we) begin
        case (sel)
          REG_RISE:  rise_sel <= wdata;
          REG_FALL:  fall_sel <= wdata;
          REG_IMASK: imask    <= wdata;
          REG_EMASK: emask    <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      REG_RISE:  rd_mux = rise_sel;
      REG_FALL:  rd_mux = fall_sel;
      REG_IMASK: rd_mux = imask;
      REG_EMASK: rd_mux = emask;
      REG_PEND:  rd_mux = pend_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // Software trigger lives one cycle unless rewritten (R9)
  p_swtrig_selfclear_r9: assert property (@(posedge clk) disable iff (rst)
    ((swtrig != '0) && !hit_sw) |=> (swtrig == '0));
endmodule

// File: rtl/eil_pending.sv
module eil_pending #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] hit,
  input  logic [NUM_LINES-1:0] swtrig,
  input  logic [NUM_LINES-1:0] clr,
  input  logic [NUM_LINES-1:0] imask,
  input  logic [NUM_LINES-1:0] emask,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [NUM_LINES-1:0] evt_o
);
  logic [NUM_LINES-1:0] set_v;

  assign set_v = hit | swtrig;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_o  <= '0;
      evt_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | set_v;
      irq_o  <= pend_q & imask;
      evt_o  <= hit & emask;
    end
  end

  // Set bits not being cleared stay set (R5)
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr)));

  // Set beats clear in the same cycle (R6)
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ((set_v & clr) != '0) |=> ((pend_q & $past(set_v & clr)) == $past(set_v & clr)));

  // A request needs a pending bit and an open mask one cycle earlier (R7)
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_o & ~($past(pend_q) & $past(imask))) == '0));

  // Event pulses only on unmasked lines (R8)
  p_evt_masked_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_o & ~$past(emask)) == '0));
endmodule

// File: rtl/eil_ctrl.sv
module eil_ctrl
  import eil_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  line_in,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_LINES-1:0]  reg_wdata,
  output logic [NUM_LINES-1:0]  reg_rdata,
  output logic [NUM_LINES-1:0]  irq_o,
  output logic [NUM_LINES-1:0]  evt_o
);
  logic [NUM_LINES-1:0] rise_sel, fall_sel, imask, emask;
  logic [NUM_LINES-1:0] swtrig, clr, hit, pend_q;

  eil_edge_detect #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .line_in(line_in),
    .rise_sel(rise_sel), .fall_sel(fall_sel), .hit(hit)
  );

  eil_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend_q(pend_q), .rise_sel(rise_sel), .fall_sel(fall_sel),
    .imask(imask), .emask(emask), .swtrig(swtrig), .clr(clr), .rdata(reg_rdata)
  );

  eil_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .hit(hit), .swtrig(swtrig), .clr(clr),
    .imask(imask), .emask(emask), .pend_q(pend_q), .irq_o(irq_o), .evt_o(evt_o)
  );

  // Outputs are zero in the cycle after reset (R1)
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> ((irq_o == '0) && (evt_o == '0) && (reg_rdata == '0)));
endmodule

// File: tb/eil_ctrl_tb.sv
module eil_ctrl_tb;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] line_in = '0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, irq_o, evt_o;

  always #10 clk = ~clk;

  eil_ctrl u_dut (
    .clk(clk), .rst(rst), .line_in(line_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  // behavioural reference state
  logic [N-1:0] m_rs, m_fs, m_im, m_em, m_sw, m_pend, m_irq, m_evt, m_rd;
  logic [N-1:0] hist[$];
  int vectors = 0;
  int errors  = 0;
  string tag = "R1";
  bit done = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic model_update();
    logic [N-1:0] rise, fall, det, clrv, rd, n_pend;
    if (rst) begin
      m_rs = '0; m_fs = '0; m_im = '0; m_em = '0; m_sw = '0;
      m_pend = '0; m_irq = '0; m_evt = '0; m_rd = '0;
      hist = {'0, '0, '0};
    end else begin
      rise = hist[1] & ~hist[2];
      fall = ~hist[1] & hist[2];
      det  = (rise & m_rs) | (fall & m_fs);
      clrv = (reg_we && reg_addr == 3'd5) ? reg_wdata : '0;
      case (reg_addr)
        3'd0: rd = m_rs;
        3'd1: rd = m_fs;
        3'd2: rd = m_im;
        3'd3: rd = m_em;
        3'd5: rd = m_pend;
        default: rd = '0;
      endcase
      m_rd   = rd;
      m_irq  = m_pend & m_im;
      m_evt  = det & m_em;
      n_pend = (m_pend & ~clrv) | det | m_sw;
      m_pend = n_pend;
      m_sw   = (reg_we && reg_addr == 3'd4) ? reg_wdata : '0;
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_rs = reg_wdata;
          3'd1: m_fs = reg_wdata;
          3'd2: m_im = reg_wdata;
          3'd3: m_em = reg_wdata;
          default: ;
        endcase
      end
      hist.push_front(line_in);
      void'(hist.pop_back());
    end
  endtask

  task automatic compare();
    vectors++;
    if (irq_o !== m_irq || evt_o !== m_evt || reg_rdata !== m_rd) begin
      errors++;
      $display("FAIL %s: irq=%h evt=%h rdata=%h expected irq=%h evt=%h rdata=%h",
               tag, irq_o, evt_o, reg_rdata, m_irq, m_evt, m_rd);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    reg_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    tag = "R1 reset";
    tick(); tick();
    rst = 1'b0;
    for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); tick(); end

    tag = "R10 register map";
    wr(3'd0, 16'hA5A5); wr(3'd1, 16'h0F0F); wr(3'd2, 16'h3C3C);
    wr(3'd3, 16'hFFFF); wr(3'd6, 16'hFFFF); wr(3'd4, 16'h0000);
    for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); tick(); end

    tag = "R3 rising select";
    wr(3'd0, 16'h00FF); wr(3'd1, 16'h0000);
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'h0F0F);
    reg_addr = 3'd5;
    line_in = 16'hFFFF; idle(5);
    tag = "R2 latency";
    line_in = 16'h0000; idle(5);

    tag = "R5 write one to clear";
    wr(3'd5, 16'h0005); reg_addr = 3'd5; idle(2);
    wr(3'd5, 16'h0000); reg_addr = 3'd5; idle(2);
    wr(3'd5, 16'hFFFF); reg_addr = 3'd5; idle(2);

    tag = "R4 falling and both";
    wr(3'd0, 16'hF000); wr(3'd1, 16'hFF00);
    reg_addr = 3'd5;
    line_in = 16'hFFFF; idle(4);
    line_in = 16'h0000; idle(4);
    tag = "R4 neither selected";
    wr(3'd5, 16'hFFFF);
    line_in = 16'h00FF; idle(4);
    line_in = 16'h0000; idle(4);

    tag = "R7 interrupt mask";
    wr(3'd2, 16'h0000); wr(3'd0, 16'hFFFF);
    line_in = 16'hFFFF; idle(5);
    wr(3'd2, 16'h00F0); idle(3);
    wr(3'd2, 16'hFFFF); idle(3);

    tag = "R6 edge beats clear";
    // pending already set; new edge detected in the cycle of the clear
    line_in = 16'h0000; tick(); tick();
    wr(3'd1, 16'hFFFF);
    line_in = 16'hFFFF; tick(); tick();
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 16'hFFFF; tick();
    reg_addr = 3'd5; idle(3);

    tag = "R9 software trigger";
    wr(3'd5, 16'hFFFF); idle(2);
    wr(3'd4, 16'h8001); reg_addr = 3'd4; idle(3);
    reg_addr = 3'd5; tick();
    tag = "R6 trigger beats clear";
    wr(3'd4, 16'h0100);
    wr(3'd5, 16'h0101); reg_addr = 3'd5; idle(3);
    tag = "R8 event independent of interrupt mask";
    wr(3'd2, 16'h0000); wr(3'd3, 16'h00FF);
    line_in = 16'h0000; idle(5);
    wr(3'd4, 16'h00FF); idle(3);

    tag = "R2 pseudo-random mix";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 4'd3) line_in = line_in ^ lfsr[31:16];
      reg_we    = (lfsr[7:5] == 3'd0);
      reg_addr  = lfsr[10:8];
      reg_wdata = lfsr[26:11];
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule